// File: doc/BRIEF.md
# Width-Converting Parity Buffer for a DMA Port

This block is a sixteen-entry buffer that sits between a SCSI-side transfer engine and a DMA port. Each entry is two data bytes, and each byte has its own parity bit. Either side can run 8 bits wide or 16 bits wide, and the two widths are set independently. When a narrow side meets a wide side, the buffer packs bytes into words or splits words into bytes. A direction bit chooses which side fills the buffer and which side drains it.

On the DMA side the buffer raises a request whenever a transfer is possible. A transfer happens in any clock cycle where the acknowledge is at its active level and the strobe for the current direction is low. Software sets the active level of the request and of the acknowledge separately. The buffer reports a word count and a byte count, so the engine can hold the synchronous offset to the capacity: sixteen words, or thirty-two bytes. It also keeps three sticky error flags: overflow, underflow and parity.

Top module: `par_width_fifo`

## Requirements
- R1: After reset, `buf_empty`=1, `buf_full`=0, `lvl_words`=0, `lvl_bytes`=0 and all three error flags are 0. `dma_req` sits at its inactive level when the buffer is in the DMA-drains direction.
- R2: With both sides 16 bits wide, words come out in the order they went in. Up to 16 words are held, and `buf_full` is 1 when 16 words are held.
- R3: A writer 8 bits wide presents each byte on lane bits [7:0] with its parity on parity bit 0. The first byte fills the low half of an entry and the second byte fills the high half. `lvl_bytes` grows by one per byte, while `lvl_words` grows only when the high half arrives. A reader 16 bits wide then sees {second byte, first byte}.
- R4: A reader 8 bits wide gets the low byte of an entry first and then the high byte, on lane bits [7:0], with bits [15:8] reading zero. An entry is freed (`lvl_words` falls) only after its high byte is read.
- R5: A `flush` pulse while a low half is pending completes that entry with high byte 0x00 and high parity 1. `lvl_words` then grows by one and `lvl_bytes` rounds up to even.
- R6: Parity bits come out on the same lanes they went in on. The parity is odd: the byte together with its parity bit has an odd number of ones. If a byte is read out with mismatching parity, the sticky `err_par` is set.
- R7: A write while `buf_full`=1 is ignored: the counts do not change. It sets the sticky `err_over`.
- R8: A read while `buf_empty`=1 is ignored: the counts do not change. It sets the sticky `err_under`.
- R9: `dma_req` is active in two cases: in the DMA-drains direction while data is held, and in the DMA-fills direction while space remains. It is active high when `cfg_req_hi`=1 and active low when `cfg_req_hi`=0.
- R10: In the same cycle that a qualified DMA transfer is the last one possible, `dma_req` goes inactive without waiting for a clock edge. The last transfer is the one that empties the buffer in the drains direction, or fills it in the fills direction.
- R11: A DMA transfer needs `dma_ack` equal to `cfg_ack_hi`. With the acknowledge at its other level, a low strobe moves nothing.
- R12: With an 8-bit writer, 32 bytes fit. `lvl_bytes` then reads 32 and `buf_full` reads 1.
- R13: In the DMA-drains direction, `dma_wr_n` has no effect. In the DMA-fills direction, `dma_rd_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_to_dma | input | 1 | 1: SCSI side fills and DMA side drains; 0: the reverse |
| cfg_scsi_wide | input | 1 | SCSI side width, 1 = 16 bits |
| cfg_dma_wide | input | 1 | DMA side width, 1 = 16 bits |
| cfg_req_hi | input | 1 | Request active level, 1 = high |
| cfg_ack_hi | input | 1 | Acknowledge active level, 1 = high |
| flush | input | 1 | Complete a half-filled entry |
| scsi_push | input | 1 | SCSI-side write strobe (drains direction of DMA) |
| scsi_pop | input | 1 | SCSI-side read strobe (fills direction of DMA) |
| scsi_wdata | input | 16 | SCSI write data |
| scsi_wpar | input | 2 | SCSI write parity, bit 1 for the high byte |
| scsi_rdata | output | 16 | SCSI read data (head of buffer) |
| scsi_rpar | output | 2 | SCSI read parity |
| dma_req | output | 1 | DMA request, polarity from cfg_req_hi |
| dma_ack | input | 1 | DMA acknowledge, polarity from cfg_ack_hi |
| dma_rd_n | input | 1 | DMA read strobe, active low |
| dma_wr_n | input | 1 | DMA write strobe, active low |
| dma_wdata | input | 16 | DMA write data |
| dma_wpar | input | 2 | DMA write parity |
| dma_rdata | output | 16 | DMA read data (head of buffer) |
| dma_rpar | output | 2 | DMA read parity |
| buf_full | output | 1 | No entry free |
| buf_empty | output | 1 | No complete entry held |
| lvl_words | output | 5 | Complete entries held, 0 to 16 |
| lvl_bytes | output | 6 | Bytes held, 0 to 32 |
| err_over | output | 1 | Sticky overflow flag |
| err_under | output | 1 | Sticky underflow flag |
| err_par | output | 1 | Sticky parity error flag |

## Verification
The assertions rely on a few things about the inputs:
- Width and direction settings change only while the buffer is empty and no half entry is pending.
- A 16-bit access never lands on a half-filled or half-read entry.
- `flush` is never pulsed in the same cycle as a write.

The bench keeps to these rules. It changes the configuration only inside its reset task, and it pairs each narrow mode only with whole-word traffic on the other side. Each strobe lasts one cycle, and the acknowledge is driven active only for that cycle, so every qualified strobe counts as exactly one transfer.

// File: rtl/par_width_fifo.sv
module par_width_fifo #(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8,
  localparam int DW  = 2 * BYTE_W,
  localparam int EW  = DW + 2,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = AW + 1,
  localparam int BCW = AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_to_dma,
  input  logic          cfg_scsi_wide,
  input  logic          cfg_dma_wide,
  input  logic          cfg_req_hi,
  input  logic          cfg_ack_hi,
  input  logic          flush,
  input  logic          scsi_push,
  input  logic          scsi_pop,
  input  logic [DW-1:0] scsi_wdata,
  input  logic [1:0]    scsi_wpar,
  output logic [DW-1:0] scsi_rdata,
  output logic [1:0]    scsi_rpar,
  output logic          dma_req,
  input  logic          dma_ack,
  input  logic          dma_rd_n,
  input  logic          dma_wr_n,
  input  logic [DW-1:0] dma_wdata,
  input  logic [1:0]    dma_wpar,
  output logic [DW-1:0] dma_rdata,
  output logic [1:0]    dma_rpar,
  output logic          buf_full,
  output logic          buf_empty,
  output logic [CW-1:0] lvl_words,
  output logic [BCW-1:0] lvl_bytes,
  output logic          err_over,
  output logic          err_under,
  output logic          err_par
);

  // entry layout: {par_hi, byte_hi, par_lo, byte_lo}
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] wcnt;
  logic          wr_half, rd_half;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic wr_wide, rd_wide, ack_on, dma_x, push_req, pop_req;
  logic push_ok, pop_ok, flush_ok, cmt_w, rel_w;
  logic [DW-1:0] w_data;
  logic [1:0]    w_par;

  assign wr_wide  = cfg_to_dma ? cfg_scsi_wide : cfg_dma_wide;
  assign rd_wide  = cfg_to_dma ? cfg_dma_wide  : cfg_scsi_wide;
  assign ack_on   = (dma_ack == cfg_ack_hi);
  assign dma_x    = ack_on && (cfg_to_dma ? !dma_rd_n : !dma_wr_n);
  assign push_req = cfg_to_dma ? scsi_push : dma_x;
  assign pop_req  = cfg_to_dma ? dma_x : scsi_pop;
  assign w_data   = cfg_to_dma ? scsi_wdata : dma_wdata;
  assign w_par    = cfg_to_dma ? scsi_wpar  : dma_wpar;

  assign buf_full  = (wcnt == CW'(DEPTH));
  assign buf_empty = (wcnt == '0);
  assign push_ok   = push_req && !buf_full;
  assign pop_ok    = pop_req && !buf_empty;
  assign flush_ok  = flush && !push_req && wr_half;
  assign cmt_w     = (push_ok && (wr_wide || wr_half)) || flush_ok;
  assign rel_w     = pop_ok && (rd_wide || rd_half);

  logic [EW-1:0]     head;
  logic [BYTE_W-1:0] lo_b, hi_b;
  logic              lo_p, hi_p, bad_lo, bad_hi, par_bad;
  logic [DW-1:0]     rd_data;
  logic [1:0]        rd_par;

  assign head   = mem[rp];
  assign lo_b   = head[BYTE_W-1:0];
  assign lo_p   = head[BYTE_W];
  assign hi_b   = head[EW-2:BYTE_W+1];
  assign hi_p   = head[EW-1];
  assign bad_lo = ~^{lo_b, lo_p};
  assign bad_hi = ~^{hi_b, hi_p};
  assign par_bad = rd_wide ? (bad_lo || bad_hi) : (rd_half ? bad_hi : bad_lo);

  assign rd_data = rd_wide ? {hi_b, lo_b} : {{BYTE_W{1'b0}}, rd_half ? hi_b : lo_b};
  assign rd_par  = rd_wide ? {hi_p, lo_p} : {1'b0, rd_half ? hi_p : lo_p};
  assign scsi_rdata = rd_data;
  assign scsi_rpar  = rd_par;
  assign dma_rdata  = rd_data;
  assign dma_rpar   = rd_par;

  always_ff @(posedge clk) begin
    if (push_ok) begin
      if (wr_wide)
        mem[wp] <= {w_par[1], w_data[DW-1:BYTE_W], w_par[0], w_data[BYTE_W-1:0]};
      else if (!wr_half)
        mem[wp][BYTE_W:0] <= {w_par[0], w_data[BYTE_W-1:0]};
      else
        mem[wp][EW-1:BYTE_W+1] <= {w_par[0], w_data[BYTE_W-1:0]};
    end else if (flush_ok) begin
      mem[wp][EW-1:BYTE_W+1] <= {1'b1, {BYTE_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      wcnt <= '0;
      wr_half <= 1'b0;
      rd_half <= 1'b0;
      err_over <= 1'b0;
      err_under <= 1'b0;
      err_par <= 1'b0;
    end else begin
      if (cmt_w) wp <= nxt(wp);
      if (push_ok) wr_half <= !wr_wide && !wr_half;
      else if (flush_ok) wr_half <= 1'b0;
      if (rel_w) rp <= nxt(rp);
      if (pop_ok) rd_half <= !rd_wide && !rd_half;
      wcnt <= wcnt + CW'(cmt_w) - CW'(rel_w);
      if (push_req && buf_full) err_over <= 1'b1;
      if (pop_req && buf_empty) err_under <= 1'b1;
      if (pop_ok && par_bad) err_par <= 1'b1;
    end
  end

  assign lvl_words = wcnt;
  assign lvl_bytes = BCW'({wcnt, 1'b0}) + BCW'(wr_half) - BCW'(rd_half);

  logic avail, last_x, req_int;
  assign avail  = cfg_to_dma ? !buf_empty : !buf_full;
  assign last_x = cfg_to_dma ? (wcnt == CW'(1) && (rd_wide || rd_half))
                             : (wcnt == CW'(DEPTH - 1) && (wr_wide || wr_half));
  assign req_int = avail && !(dma_x && last_x);
  assign dma_req = cfg_req_hi ? req_int : !req_int;

  a_r7_over_hold: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && buf_full && !pop_ok |=> lvl_words == $past(lvl_words));
  a_r7_over_flag: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && buf_full |=> err_over);
  a_r8_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && buf_empty && !push_ok && !flush_ok |=> err_under && lvl_bytes == $past(lvl_bytes));
  a_r9_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_to_dma && buf_empty |-> dma_req != cfg_req_hi);
  a_r12_bytes_max: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_bytes <= BCW'(2 * DEPTH));
  a_r6_par_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok && par_bad |=> err_par);
  a_r3_byte_pack: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && !wr_wide && !wr_half && !pop_ok |=>
      lvl_words == $past(lvl_words) && lvl_bytes == $past(lvl_bytes) + 1'b1);

endmodule

// File: tb/test_par_width_fifo.sv
module test_par_width_fifo;
  logic clk = 0, rst_n = 0;
  logic cfg_to_dma = 1, cfg_scsi_wide = 1, cfg_dma_wide = 1, cfg_req_hi = 1, cfg_ack_hi = 1;
  logic flush = 0, scsi_push = 0, scsi_pop = 0;
  logic [15:0] scsi_wdata = 0, dma_wdata = 0;
  logic [1:0] scsi_wpar = 0, dma_wpar = 0;
  logic dma_ack = 0, dma_rd_n = 1, dma_wr_n = 1;
  logic [15:0] scsi_rdata, dma_rdata;
  logic [1:0] scsi_rpar, dma_rpar;
  logic dma_req, buf_full, buf_empty, err_over, err_under, err_par;
  logic [4:0] lvl_words;
  logic [5:0] lvl_bytes;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  par_width_fifo i_par_width_fifo (.*);

  localparam logic [15:0] TBL [16] = '{16'h1234, 16'hABCD, 16'h0000, 16'hFFFF,
    16'h8001, 16'h7F7F, 16'h5AA5, 16'h0F0F, 16'hC3C3, 16'h0102, 16'hFE10, 16'h4444,
    16'h9999, 16'h6E6E, 16'h2B3C, 16'hD00D};

  function automatic logic op(input logic [7:0] b);
    return ~^b;
  endfunction
  function automatic logic [1:0] p2(input logic [15:0] w);
    return {op(w[15:8]), op(w[7:0])};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic to_dma, input logic sw, input logic dw,
                          input logic rq, input logic ak);
    @(negedge clk);
    rst_n = 0;
    cfg_to_dma = to_dma; cfg_scsi_wide = sw; cfg_dma_wide = dw;
    cfg_req_hi = rq; cfg_ack_hi = ak; dma_ack = ~ak;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
  endtask

  task automatic s_wr(input logic [15:0] d, input logic [1:0] p);
    @(negedge clk);
    scsi_wdata = d; scsi_wpar = p; scsi_push = 1;
    @(negedge clk);
    scsi_push = 0;
    #1;
  endtask

  task automatic s_rd();
    @(negedge clk);
    scsi_pop = 1;
    @(negedge clk);
    scsi_pop = 0;
    #1;
  endtask

  task automatic d_rd();
    @(negedge clk);
    dma_ack = cfg_ack_hi; dma_rd_n = 0;
    @(negedge clk);
    dma_ack = ~cfg_ack_hi; dma_rd_n = 1;
    #1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    do_reset(1, 1, 1, 1, 1);
    chk("R1 empty", buf_empty, 1);
    chk("R1 full", buf_full, 0);
    chk("R1 bytes", lvl_bytes, 0);
    chk("R1 words", lvl_words, 0);
    chk("R1 flags", {err_over, err_under, err_par}, 0);
    chk("R1 req idle", dma_req, 0);

    for (int i = 0; i < 16; i++) begin
      s_wr(TBL[i], p2(TBL[i]));
      chk("R2 level", lvl_words, i + 1);
      chk("R9 req with data", dma_req, 1);
    end
    chk("R2 full", buf_full, 1);
    s_wr(16'hEEEE, 2'b00);
    chk("R7 over flag", err_over, 1);
    chk("R7 words held", lvl_words, 16);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      #1;
      chk("R2 order", dma_rdata, TBL[i]);
      chk("R6 parity lanes", dma_rpar, p2(TBL[i]));
      dma_ack = 1; dma_rd_n = 0;
      #1;
      chk("R10 req on ack", dma_req, (i != 15));
      @(negedge clk);
      dma_ack = 0; dma_rd_n = 1;
    end
    #1;
    chk("R2 drained", buf_empty, 1);
    chk("R7 over not a word", err_par, 0);
    d_rd();
    chk("R8 under flag", err_under, 1);
    chk("R8 bytes held", lvl_bytes, 0);

    do_reset(1, 0, 1, 1, 1);
    begin
      logic [7:0] bs [5] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5};
      for (int k = 0; k < 5; k++) begin
        s_wr({8'h00, bs[k]}, {1'b0, op(bs[k])});
        chk("R3 byte count", lvl_bytes, k + 1);
        chk("R3 word count", lvl_words, (k + 1) / 2);
      end
    end
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    #1;
    chk("R5 bytes round", lvl_bytes, 6);
    chk("R5 words", lvl_words, 3);
    chk("R3 packed word0", dma_rdata, 16'hB2A1);
    d_rd();
    chk("R3 packed word1", dma_rdata, 16'hD4C3);
    d_rd();
    chk("R5 pad data", dma_rdata, 16'h00E5);
    chk("R5 pad parity", dma_rpar, {1'b1, op(8'hE5)});
    d_rd();
    chk("R5 drained", buf_empty, 1);

    do_reset(1, 1, 0, 0, 0);
    chk("R9 low idle", dma_req, 1);
    s_wr(16'h5A3C, p2(16'h5A3C));
    s_wr(16'h7E81, p2(16'h7E81));
    chk("R9 low active", dma_req, 0);
    @(negedge clk); dma_ack = 1; dma_rd_n = 0;
    @(negedge clk); dma_rd_n = 1;
    #1;
    chk("R11 wrong ack level", lvl_bytes, 4);
    @(negedge clk); dma_ack = 0; dma_wr_n = 0;
    @(negedge clk); dma_ack = 1; dma_wr_n = 1;
    #1;
    chk("R13 unused strobe", lvl_bytes, 4);
    begin
      logic [7:0] eb [4] = '{8'h3C, 8'h5A, 8'h81, 8'h7E};
      for (int k = 0; k < 4; k++) begin
        chk("R4 byte order", dma_rdata, {8'h00, eb[k]});
        chk("R4 byte parity", dma_rpar, {1'b0, op(eb[k])});
        d_rd();
        chk("R4 bytes left", lvl_bytes, 3 - k);
        chk("R4 words left", lvl_words, (3 - k + 1) / 2);
      end
    end

    do_reset(1, 0, 1, 1, 1);
    for (int k = 0; k < 32; k++) s_wr(16'(k), {1'b0, op(8'(k))});
    chk("R12 bytes 32", lvl_bytes, 32);
    chk("R12 full", buf_full, 1);
    s_wr(16'h0077, 2'b00);
    chk("R7 byte over", err_over, 1);
    chk("R12 still 32", lvl_bytes, 32);

    do_reset(1, 1, 1, 1, 1);
    s_wr(16'h00FF, 2'b10);
    chk("R6 bad parity carried", dma_rpar, 2'b10);
    chk("R6 no flag yet", err_par, 0);
    d_rd();
    chk("R6 flag set", err_par, 1);
    s_wr(16'h1234, p2(16'h1234));
    d_rd();
    chk("R6 sticky", err_par, 1);

    do_reset(0, 1, 1, 1, 1);
    chk("R9 space req", dma_req, 1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      dma_wdata = TBL[i]; dma_wpar = p2(TBL[i]);
      dma_ack = 1; dma_wr_n = 0;
      #1;
      chk("R10 fill req", dma_req, (i != 15));
      @(negedge clk);
      dma_ack = 0; dma_wr_n = 1;
    end
    #1;
    chk("R9 full no req", dma_req, 0);
    chk("R2 fill full", buf_full, 1);
    chk("R2 scsi head", scsi_rdata, TBL[0]);
    s_rd();
    chk("R2 scsi next", scsi_rdata, TBL[1]);
    chk("R9 space again", dma_req, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule